// File: doc/BRIEF.md
# Completion queue with branch-gated retirement

The block keeps dispatched instructions in program order and moves them into architected state in that same order. Each slot holds the instruction tag and a finished flag. It also holds a flag that marks the slot as lying in the shadow of an unresolved predicted branch. For a branch, the slot holds a pending link-register load and a pending count-register decrement. Slot 0 is always the oldest entry. Retirement shifts the whole queue down.

Dispatch offers up to two instructions per cycle, and the lower slot is the older one. The execution side reports finished instructions by tag. The branch unit reports each prediction as correct or mispredicted, also by tag. A mispredict discards every entry younger than the branch and puts the tail directly behind it. The branch itself and all older entries still retire. The link and count registers are written only when their branch retires. At most two unresolved predicted branches may be present in the queue at one time.

Top module: `completion_queue`

## Requirements
- R1: After reset the queue is empty. `full_o` is 0, no retire strobe is high, `arch_lr_o` is 0 and `arch_ctr_o` equals CTR_INIT. With nothing offered, `disp_rdy_o` is 1.
- R2: Retirement starts at slot 0 and takes at most two entries per cycle. It stops at the first entry that is unfinished or speculative. `ret_vld_o[1]` is high only together with `ret_vld_o[0]`, and bit 0 is the older entry.
- R3: A finished non-branch entry at the head retires in the cycle that follows the clock edge which registered its finish.
- R4: Dispatch slot 0 is older than slot 1. A branch in slot 0 and a plain instruction in slot 1 enter the queue in the same cycle. Slot 1 is offered only together with slot 0.
- R5: `full_o` is high when all six slots are occupied. `disp_rdy_o` is low, and nothing is written, when fewer slots are free than the number of instructions offered.
- R6: An entry that is younger than an unresolved branch never retires, even when it has finished.
- R7: When a branch resolves correctly, the branch and its finished younger entries become eligible to retire in the next cycle.
- R8: A mispredict discards all entries younger than the branch, so they never retire. The tail moves to the slot right behind the branch, and the branch retires in the next cycle. `disp_rdy_o` is low in the mispredict cycle.
- R9: A branch that is marked resolved at dispatch and reaches the head retires in the cycle after its dispatch edge. `lr_we_o` and `ctr_we_o` are high in that same cycle when the branch carries those updates.
- R10: `arch_ctr_o` drops by one for each retiring branch with the decrement flag. `arch_lr_o` loads the value carried by the branch. Both changes are visible one cycle after the retire strobe, and both registers hold their values otherwise.
- R11: At most two unresolved branches may be in the queue. An offer that would bring in a third one is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_vld_i | input | DISP_W | Dispatch slot valid, slot 0 oldest |
| disp_tag_i | input | DISP_W x TAG_W | Instruction tag per slot |
| disp_br_i | input | DISP_W | Slot holds a branch |
| disp_res_i | input | DISP_W | Branch already resolved at dispatch |
| disp_lr_we_i | input | DISP_W | Branch loads the link register |
| disp_lr_val_i | input | DISP_W x LR_W | Link value carried by the branch |
| disp_ctr_dec_i | input | DISP_W | Branch decrements the count register |
| disp_rdy_o | output | 1 | Offered dispatch group accepted |
| fin_vld_i | input | 1 | Execution finished |
| fin_tag_i | input | TAG_W | Tag of finished instruction |
| res_vld_i | input | 1 | Branch resolved |
| res_tag_i | input | TAG_W | Tag of resolved branch |
| res_mis_i | input | 1 | Resolution was a mispredict |
| ret_vld_o | output | RET_W | Retire strobes, bit 0 oldest |
| ret_tag_o | output | RET_W x TAG_W | Tags of retiring entries |
| lr_we_o | output | 1 | Link register written this cycle |
| ctr_we_o | output | 1 | Count register written this cycle |
| arch_lr_o | output | LR_W | Architected link register |
| arch_ctr_o | output | CTR_W | Architected count register |
| full_o | output | 1 | All slots occupied |

## Verification
Each input is sampled on one clock edge. A finish, a resolve or an already-resolved dispatch raises the retire strobe in the cycle right after that edge. The architected link and count registers change one cycle after the strobe. `disp_rdy_o` is combinational, so it reflects the current offer in the same cycle.

The bench drives its inputs just after the rising edge and reads every output at the falling edge that follows the edge in question. A scoreboard queue holds the expected retire order. A monitor pops it on every strobe, so a purged tag or a reordering shows up as a mismatch.

// File: rtl/cq_pkg.sv
package cq_pkg;
  parameter int TAG_W = 4;
  parameter int LR_W  = 32;

  typedef struct packed {
    logic             vld;
    logic [TAG_W-1:0] tag;
    logic             br;
    logic             done;     // finished, or resolved for a branch
    logic             spec;     // an older unresolved branch exists
    logic             lr_we;
    logic [LR_W-1:0]  lr_val;
    logic             ctr_dec;
  } cq_ent_t;
endpackage

// File: rtl/cq_tag_find.sv
module cq_tag_find
  import cq_pkg::*;
#(
  parameter int DEPTH   = 6,
  parameter bit BR_ONLY = 1'b0,
  localparam int IW     = $clog2(DEPTH)
) (
  input  cq_ent_t          ent_i [DEPTH],
  input  logic             req_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             hit_o,
  output logic [IW-1:0]    idx_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (req_i && ent_i[i].vld && ent_i[i].tag == tag_i &&
          (!BR_ONLY || (ent_i[i].br && !ent_i[i].done))) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/cq_retire_sel.sv
module cq_retire_sel
  import cq_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int RET_W  = 2,
  localparam int CW    = $clog2(RET_W + 1)
) (
  input  cq_ent_t          ent_i [DEPTH],
  output logic [RET_W-1:0] ret_vld_o,
  output logic [CW-1:0]    n_ret_o
);
  logic [RET_W-1:0] ok;

  for (genvar k = 0; k < RET_W; k++) begin : g_ret
    logic rdy;
    assign rdy = ent_i[k].vld && ent_i[k].done && !ent_i[k].spec;
    if (k == 0) begin : g_head
      assign ok[k] = rdy;
    end else begin : g_next
      assign ok[k] = ok[k-1] && rdy;
    end
  end

  assign ret_vld_o = ok;
  assign n_ret_o   = CW'($countones(ok));
endmodule

// File: rtl/cq_arch_regs.sv
module cq_arch_regs
  import cq_pkg::*;
#(
  parameter int          RET_W    = 2,
  parameter int          CTR_W    = 32,
  parameter logic [31:0] CTR_INIT = 32'd0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [RET_W-1:0]           ret_vld_i,
  input  logic [RET_W-1:0]           ret_lr_we_i,
  input  logic [RET_W-1:0][LR_W-1:0] ret_lr_val_i,
  input  logic [RET_W-1:0]           ret_dec_i,
  output logic                       lr_we_o,
  output logic                       ctr_we_o,
  output logic [LR_W-1:0]            lr_o,
  output logic [CTR_W-1:0]           ctr_o
);
  logic [RET_W-1:0] lr_sel, dec_sel;
  logic [LR_W-1:0]  lr_nxt;

  assign lr_sel   = ret_vld_i & ret_lr_we_i;
  assign dec_sel  = ret_vld_i & ret_dec_i;
  assign lr_we_o  = |lr_sel;
  assign ctr_we_o = |dec_sel;

  // youngest retiring link update wins
  always_comb begin
    lr_nxt = lr_o;
    for (int k = 0; k < RET_W; k++) if (lr_sel[k]) lr_nxt = ret_lr_val_i[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lr_o  <= '0;
      ctr_o <= CTR_W'(CTR_INIT);
    end else begin
      lr_o  <= lr_nxt;
      ctr_o <= ctr_o - CTR_W'($countones(dec_sel));
    end
  end
endmodule

// File: rtl/completion_queue.sv
module completion_queue
  import cq_pkg::*;
#(
  parameter int          DEPTH    = 6,
  parameter int          DISP_W   = 2,
  parameter int          RET_W    = 2,
  parameter int          MAX_UBR  = 2,
  parameter int          CTR_W    = 32,
  parameter logic [31:0] CTR_INIT = 32'd0,
  localparam int         IW       = $clog2(DEPTH),
  localparam int         CNT_W    = $clog2(DEPTH + 1),
  localparam int         RCW      = $clog2(RET_W + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [DISP_W-1:0]           disp_vld_i,
  input  logic [DISP_W-1:0][TAG_W-1:0] disp_tag_i,
  input  logic [DISP_W-1:0]           disp_br_i,
  input  logic [DISP_W-1:0]           disp_res_i,
  input  logic [DISP_W-1:0]           disp_lr_we_i,
  input  logic [DISP_W-1:0][LR_W-1:0] disp_lr_val_i,
  input  logic [DISP_W-1:0]           disp_ctr_dec_i,
  output logic                        disp_rdy_o,
  input  logic                        fin_vld_i,
  input  logic [TAG_W-1:0]            fin_tag_i,
  input  logic                        res_vld_i,
  input  logic [TAG_W-1:0]            res_tag_i,
  input  logic                        res_mis_i,
  output logic [RET_W-1:0]            ret_vld_o,
  output logic [RET_W-1:0][TAG_W-1:0] ret_tag_o,
  output logic                        lr_we_o,
  output logic                        ctr_we_o,
  output logic [LR_W-1:0]             arch_lr_o,
  output logic [CTR_W-1:0]            arch_ctr_o,
  output logic                        full_o
);
  cq_ent_t          ent_q [DEPTH];
  cq_ent_t          ent_m [DEPTH];
  cq_ent_t          ent_s [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fin_hit, res_hit;
  logic [IW-1:0]    fin_idx, res_idx;
  logic [RCW-1:0]   n_ret;
  logic             disp_go;
  int               n_offer, ubr_q, ubr_new;

  cq_tag_find #(.DEPTH(DEPTH), .BR_ONLY(1'b0)) i_fin_find (
    .ent_i(ent_q), .req_i(fin_vld_i), .tag_i(fin_tag_i), .hit_o(fin_hit), .idx_o(fin_idx)
  );

  cq_tag_find #(.DEPTH(DEPTH), .BR_ONLY(1'b1)) i_res_find (
    .ent_i(ent_q), .req_i(res_vld_i), .tag_i(res_tag_i), .hit_o(res_hit), .idx_o(res_idx)
  );

  cq_retire_sel #(.DEPTH(DEPTH), .RET_W(RET_W)) i_ret_sel (
    .ent_i(ent_q), .ret_vld_o(ret_vld_o), .n_ret_o(n_ret)
  );

  logic [RET_W-1:0]           r_lr_we, r_dec;
  logic [RET_W-1:0][LR_W-1:0] r_lr_val;

  for (genvar k = 0; k < RET_W; k++) begin : g_rout
    assign ret_tag_o[k] = ent_q[k].tag;
    assign r_lr_we[k]   = ent_q[k].br && ent_q[k].lr_we;
    assign r_lr_val[k]  = ent_q[k].lr_val;
    assign r_dec[k]     = ent_q[k].br && ent_q[k].ctr_dec;
  end

  cq_arch_regs #(.RET_W(RET_W), .CTR_W(CTR_W), .CTR_INIT(CTR_INIT)) i_arch (
    .clk_i, .rst_ni,
    .ret_vld_i(ret_vld_o), .ret_lr_we_i(r_lr_we), .ret_lr_val_i(r_lr_val), .ret_dec_i(r_dec),
    .lr_we_o, .ctr_we_o, .lr_o(arch_lr_o), .ctr_o(arch_ctr_o)
  );

  // admission: space, speculation depth, no purge in flight
  always_comb begin
    n_offer = $countones(disp_vld_i);
    ubr_q   = 0;
    ubr_new = 0;
    for (int i = 0; i < DEPTH; i++)
      if (ent_q[i].vld && ent_q[i].br && !ent_q[i].done) ubr_q++;
    for (int k = 0; k < DISP_W; k++)
      if (disp_vld_i[k] && disp_br_i[k] && !disp_res_i[k]) ubr_new++;
  end

  assign disp_rdy_o = (n_offer <= DEPTH - int'(cnt_q)) && (ubr_q + ubr_new <= MAX_UBR) &&
                      !(res_hit && res_mis_i);
  assign disp_go    = disp_rdy_o && (|disp_vld_i);
  assign full_o     = (int'(cnt_q) == DEPTH);

  always_comb begin
    int  cnt_m;
    logic seen;
    ent_m = ent_q;
    cnt_m = int'(cnt_q);
    if (fin_hit) ent_m[fin_idx].done = 1'b1;
    if (res_hit) begin
      ent_m[res_idx].done = 1'b1;
      if (res_mis_i) begin
        for (int i = 0; i < DEPTH; i++) if (i > int'(res_idx)) ent_m[i] = '0;
        cnt_m = int'(res_idx) + 1;
      end
    end
    // shift out retired head entries
    for (int i = 0; i < DEPTH; i++) begin
      ent_s[i] = '0;
      for (int j = 0; j < DEPTH; j++) if (j == i + int'(n_ret)) ent_s[i] = ent_m[j];
    end
    cnt_m = cnt_m - int'(n_ret);
    // append at tail
    if (disp_go) begin
      for (int k = 0; k < DISP_W; k++) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (disp_vld_i[k] && i == cnt_m + k) begin
            ent_s[i].vld     = 1'b1;
            ent_s[i].tag     = disp_tag_i[k];
            ent_s[i].br      = disp_br_i[k];
            ent_s[i].done    = disp_br_i[k] && disp_res_i[k];
            ent_s[i].spec    = 1'b0;
            ent_s[i].lr_we   = disp_lr_we_i[k];
            ent_s[i].lr_val  = disp_lr_val_i[k];
            ent_s[i].ctr_dec = disp_ctr_dec_i[k];
          end
        end
      end
      cnt_m = cnt_m + n_offer;
    end
    // shadow flag from the new order
    seen = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      ent_s[i].spec = seen && ent_s[i].vld;
      if (ent_s[i].vld && ent_s[i].br && !ent_s[i].done) seen = 1'b1;
    end
    cnt_d = CNT_W'(cnt_m);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else begin
      cnt_q <= cnt_d;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_s[i];
    end
  end
endmodule

// File: rtl/cq_checker.sv
module cq_checker #(
  parameter int DEPTH = 6,
  parameter int DISP_W = 2,
  parameter int RET_W = 2,
  parameter int LR_W = 32,
  parameter int CTR_W = 32,
  parameter int CNT_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DISP_W-1:0] disp_vld_i,
  input logic              disp_rdy_o,
  input logic              full_o,
  input logic [RET_W-1:0]  ret_vld_o,
  input logic              lr_we_o,
  input logic              ctr_we_o,
  input logic [LR_W-1:0]   arch_lr_o,
  input logic [CTR_W-1:0]  arch_ctr_o,
  input logic              res_vld_i,
  input logic              res_mis_i,
  input logic              res_hit,
  input logic [CNT_W-1:0]  cnt_q
);
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni) (full_o && |disp_vld_i) |-> !disp_rdy_o); // R5
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni) int'(cnt_q) <= DEPTH); // R5
  AST_RET_HEAD_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni) ret_vld_o[1] |-> ret_vld_o[0]); // R2
  AST_CTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) !ctr_we_o |=> $stable(arch_ctr_o)); // R10
  AST_LR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) !lr_we_o |=> $stable(arch_lr_o)); // R10
  AST_CTR_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni) ctr_we_o |=> !$stable(arch_ctr_o)); // R10
  AST_PURGE_BLOCKS_DISP: assert property (@(posedge clk_i) disable iff (!rst_ni) (res_vld_i && res_mis_i && res_hit) |-> !disp_rdy_o); // R8
endmodule

bind completion_queue cq_checker #(
  .DEPTH(DEPTH), .DISP_W(DISP_W), .RET_W(RET_W), .LR_W(cq_pkg::LR_W), .CTR_W(CTR_W), .CNT_W(CNT_W)
) i_cq_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .disp_vld_i(disp_vld_i), .disp_rdy_o(disp_rdy_o),
  .full_o(full_o), .ret_vld_o(ret_vld_o), .lr_we_o(lr_we_o), .ctr_we_o(ctr_we_o),
  .arch_lr_o(arch_lr_o), .arch_ctr_o(arch_ctr_o), .res_vld_i(res_vld_i),
  .res_mis_i(res_mis_i), .res_hit(res_hit), .cnt_q(cnt_q)
);

// File: tb/test_completion_queue.sv
module test_completion_queue;
  localparam int CLK_P = 20;
  localparam logic [31:0] CTR0 = 32'd10;

  logic             clk = 1'b0, rst_n = 1'b0;
  logic [1:0]       disp_vld, disp_br, disp_res, disp_lrwe, disp_dec;
  logic [1:0][3:0]  disp_tag;
  logic [1:0][31:0] disp_lrv;
  logic             disp_rdy, fin_vld, res_vld, res_mis;
  logic [3:0]       fin_tag, res_tag;
  logic [1:0]       ret_vld;
  logic [1:0][3:0]  ret_tag;
  logic             lr_we, ctr_we, full;
  logic [31:0]      arch_lr, arch_ctr;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  logic [3:0] exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  completion_queue #(.CTR_INIT(CTR0)) i_completion_queue (
    .clk_i(clk), .rst_ni(rst_n),
    .disp_vld_i(disp_vld), .disp_tag_i(disp_tag), .disp_br_i(disp_br), .disp_res_i(disp_res),
    .disp_lr_we_i(disp_lrwe), .disp_lr_val_i(disp_lrv), .disp_ctr_dec_i(disp_dec),
    .disp_rdy_o(disp_rdy), .fin_vld_i(fin_vld), .fin_tag_i(fin_tag),
    .res_vld_i(res_vld), .res_tag_i(res_tag), .res_mis_i(res_mis),
    .ret_vld_o(ret_vld), .ret_tag_o(ret_tag), .lr_we_o(lr_we), .ctr_we_o(ctr_we),
    .arch_lr_o(arch_lr), .arch_ctr_o(arch_ctr), .full_o(full)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clr();
    disp_vld = '0; disp_br = '0; disp_res = '0; disp_lrwe = '0; disp_dec = '0;
    disp_tag = '0; disp_lrv = '0;
    fin_vld = 1'b0; fin_tag = '0; res_vld = 1'b0; res_tag = '0; res_mis = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk); #1; clr();
  endtask

  // driver: sets one dispatch slot and records the expected retire order
  task automatic slot(input int k, input logic [3:0] tag, input logic br, input logic res,
                      input logic lrwe, input logic [31:0] lrv, input logic dec, input bit keep);
    disp_vld[k] = 1'b1; disp_tag[k] = tag; disp_br[k] = br; disp_res[k] = res;
    disp_lrwe[k] = lrwe; disp_lrv[k] = lrv; disp_dec[k] = dec;
    if (keep) exp_q.push_back(tag);
  endtask

  task automatic op(input int k, input logic [3:0] tag, input bit keep);
    slot(k, tag, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, keep);
  endtask

  task automatic finish(input logic [3:0] tag);
    fin_vld = 1'b1; fin_tag = tag; tick();
  endtask

  task automatic resolve(input logic [3:0] tag, input logic mis);
    res_vld = 1'b1; res_tag = tag; res_mis = mis; tick();
  endtask

  // monitor: pops expected tags as retire strobes appear (R2, R8)
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < 2; k++) begin
        if (ret_vld[k]) begin
          if (exp_q.size() == 0) chk("R8", "unexpected retire tag", longint'(ret_tag[k]), 0);
          else chk("R2", "retire order tag", longint'(ret_tag[k]), longint'(exp_q.pop_front()));
        end
      end
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      chk("R1", "watchdog expired", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    clr();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk("R1", "full_o", full, 0);
    chk("R1", "ret_vld_o", ret_vld, 0);
    chk("R1", "arch_ctr_o", arch_ctr, CTR0);
    chk("R1", "arch_lr_o", arch_lr, 0);
    chk("R1", "disp_rdy_o idle", disp_rdy, 1);

    // in-order retire, two per cycle
    op(0, 4'd1, 1); op(1, 4'd2, 1); tick();
    finish(4'd2);
    @(negedge clk); chk("R2", "younger finished alone holds", ret_vld, 2'b00);
    finish(4'd1);
    @(negedge clk); chk("R3", "pair retires after head finish", ret_vld, 2'b11);

    // resolved branch plus op in one dispatch group
    slot(0, 4'd3, 1'b1, 1'b1, 1'b1, 32'h40, 1'b1, 1); op(1, 4'd4, 1); tick();
    @(negedge clk);
    chk("R9", "branch retires cycle after dispatch", ret_vld, 2'b01);
    chk("R9", "lr_we_o", lr_we, 1);
    chk("R9", "ctr_we_o", ctr_we, 1);
    chk("R10", "ctr not yet updated", arch_ctr, CTR0);
    tick();
    @(negedge clk);
    chk("R10", "ctr after retire", arch_ctr, CTR0 - 1);
    chk("R10", "lr after retire", arch_lr, 32'h40);
    chk("R4", "slot1 op still queued", ret_vld, 2'b00);
    finish(4'd4);
    @(negedge clk); chk("R4", "slot1 op retires", ret_vld, 2'b01);

    // speculative shadow, correct resolve
    slot(0, 4'd5, 1'b1, 1'b0, 1'b0, 32'h0, 1'b1, 1); op(1, 4'd6, 1); tick();
    finish(4'd6);
    @(negedge clk); chk("R6", "shadowed op blocked", ret_vld, 2'b00);
    tick();
    @(negedge clk); chk("R6", "shadowed op still blocked", ret_vld, 2'b00);
    chk("R10", "ctr held while unresolved", arch_ctr, CTR0 - 1);
    resolve(4'd5, 1'b0);
    @(negedge clk); chk("R7", "branch and shadow retire", ret_vld, 2'b11);
    tick();
    @(negedge clk); chk("R10", "ctr after second branch", arch_ctr, CTR0 - 2);

    // mispredict purge
    op(0, 4'd7, 1); slot(1, 4'd8, 1'b1, 1'b0, 1'b0, 32'h0, 1'b1, 1); tick();
    op(0, 4'd9, 0); op(1, 4'd10, 0); tick();
    finish(4'd7);
    @(negedge clk); chk("R3", "older op retires under branch", ret_vld, 2'b01);
    finish(4'd9);
    finish(4'd10);
    @(negedge clk); chk("R6", "finished wrong-path ops blocked", ret_vld, 2'b00);
    res_vld = 1'b1; res_tag = 4'd8; res_mis = 1'b1; op(0, 4'd11, 0);
    #1; chk("R8", "disp_rdy_o during mispredict", disp_rdy, 0);
    tick();
    @(negedge clk);
    chk("R8", "mispredicted branch retires", ret_vld, 2'b01);
    chk("R8", "ctr_we_o on branch retire", ctr_we, 1);
    tick();
    @(negedge clk);
    chk("R8", "queue empty after purge", full, 0);
    chk("R10", "ctr after mispredicted branch", arch_ctr, CTR0 - 3);

    // fill to capacity
    op(0, 4'd1, 1); op(1, 4'd2, 1); tick();
    op(0, 4'd3, 1); op(1, 4'd4, 1); tick();
    op(0, 4'd5, 1); tick();
    op(0, 4'd6, 0); op(1, 4'd14, 0);
    #1; chk("R5", "refuse two with one free", disp_rdy, 0);
    clr();
    op(0, 4'd6, 1);
    #1; chk("R5", "accept one with one free", disp_rdy, 1);
    tick();
    @(negedge clk); chk("R5", "full_o at six", full, 1);
    op(0, 4'd15, 0);
    #1; chk("R5", "refuse when full", disp_rdy, 0);
    clr();
    finish(4'd6); finish(4'd5); finish(4'd4); finish(4'd3); finish(4'd2);
    @(negedge clk); chk("R2", "head unfinished blocks all", ret_vld, 2'b00);
    finish(4'd1);
    @(negedge clk); chk("R2", "two per cycle max", ret_vld, 2'b11);
    tick();
    @(negedge clk); chk("R2", "second pair", ret_vld, 2'b11);
    tick();
    @(negedge clk); chk("R2", "third pair", ret_vld, 2'b11);
    tick();

    // two-level speculation limit
    slot(0, 4'd11, 1'b1, 1'b0, 1'b0, 32'h0, 1'b0, 1);
    slot(1, 4'd12, 1'b1, 1'b0, 1'b1, 32'h88, 1'b0, 1);
    #1; chk("R11", "two unresolved accepted", disp_rdy, 1);
    tick();
    slot(0, 4'd13, 1'b1, 1'b0, 1'b0, 32'h0, 1'b0, 0);
    #1; chk("R11", "third unresolved refused", disp_rdy, 0);
    clr();
    resolve(4'd11, 1'b0);
    @(negedge clk); chk("R7", "first branch retires", ret_vld, 2'b01);
    resolve(4'd12, 1'b0);
    @(negedge clk); chk("R7", "second branch retires", ret_vld, 2'b01);
    tick();
    @(negedge clk);
    chk("R10", "lr from second branch", arch_lr, 32'h88);
    chk("R10", "ctr unchanged without decrement", arch_ctr, CTR0 - 3);
    chk("R2", "scoreboard drained", exp_q.size(), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule